// File: doc/BRIEF.md
# Programmable One-Shot / Periodic Event Timer

A memory-mapped event timer that counts down from a 56-bit start value. Each count step is triggered by an external tick strobe, which is nominally 2 MHz and arrives as a one-cycle enable. Software uses a simple 32-bit write/read port. It first writes the lower 32 bits of the count into a staging register. It then writes a control word that carries the upper 24 count bits together with three flags: run, periodic and arm. The control write sets up the whole counter in one access.

When the count runs out, the timer records a pending event and, if the event is unmasked, raises a level interrupt. The pending event stays until software clears it. The mask is changed only through separate write-one-to-set and write-one-to-clear registers. In periodic mode the timer restarts from the last armed value. In one-shot mode it stops and drops its run flag.

Top module: `evt_timer`

## Requirements
- R1: After reset, irq_o is 0 and every readable register (0x000, 0x004, 0x02c, 0x034) reads 0.
- R2: Offset 0x000 is a 32-bit read/write staging word. The control word at 0x004 holds count bits 55:32 in bits 23:0, run in bit 24, periodic in bit 28 and arm in bit 30. Bits 23:0, 24 and 28 read back as written. Bit 30 and all other bits read as 0.
- R3: A control write with bit 30 set loads the counter with {bits 23:0 of that write, staging word}. With run set, an expiry then happens on the N-th tick strobe, where N is the loaded value (0 behaves as 1). The upper 24 bits take part in the count.
- R4: The counter moves only on a tick strobe while run is set. Clock cycles without a strobe leave it unchanged.
- R5: In one-shot mode (bit 28 = 0), expiry clears the run bit and no further expiry follows.
- R6: In periodic mode, each expiry reloads the last armed 56-bit value and counting continues. A later staging-word write without arm does not change the period.
- R7: Writing 0 to the control word stops the timer, and no expiry follows.
- R8: Every expiry sets a pending flag whatever the mask is. The flag reads at bit 0 of 0x034.
- R9: Writing 1 in bit 0 of 0x02c sets the mask, and writing 1 in bit 0 of 0x030 clears it. A write with bit 0 = 0 to either register has no effect. The mask reads at bit 0 of 0x02c.
- R10: irq_o is high exactly when pending and mask are both 1.
- R11: Writing 1 in bit 0 of 0x034 clears pending. An expiry in the same cycle wins.
- R12: A tick strobe in the same cycle as a control write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle count strobe (2 MHz rate) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
Counting is exercised with several kinds of input. Small one-shot counts of 1, 3 and 5 show that the loaded value sets the exact expiry tick. A value with a nonzero upper field and a zero staging word shows that the upper 24 bits are really used. A periodic count that runs over three periods, with a staging rewrite in between, separates reload-from-armed-value from reload-from-staging. Idle clock gaps between strobes, a strobe that coincides with a control write, and a clear that coincides with an expiry separate tick-driven counting from clock-driven counting and fix which action wins on each collision.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 8;
  localparam int CNT_W       = 56;
  localparam int LOW_W       = DATA_W;
  localparam int HI_W        = CNT_W - LOW_W;

  localparam logic [ADDR_W-1:0] OFS_LOW   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTL   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_MSET  = 8'h2c;
  localparam logic [ADDR_W-1:0] OFS_MCLR  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_PCLR  = 8'h34;

  localparam int BIT_RUN  = 24;
  localparam int BIT_PER  = 28;
  localparam int BIT_ARM  = 30;
endpackage

// File: rtl/evt_timer_cnt.sv
module evt_timer_cnt #(
  parameter int CNT_W = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ctl_we,
  input  logic             ctl_arm,
  input  logic             ctl_run,
  input  logic             ctl_per,
  input  logic [CNT_W-1:0] arm_val,
  output logic             run_o,
  output logic             per_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rel_q, rel_d;
  logic             run_q, run_d, per_q, per_d;

  always_comb begin
    expire_o = run_q & tick_en & ~ctl_we & (cnt_q <= CNT_W'(1));
    cnt_d = cnt_q;
    rel_d = rel_q;
    run_d = run_q;
    per_d = per_q;
    if (ctl_we) begin
      run_d = ctl_run;
      per_d = ctl_per;
      if (ctl_arm) begin
        cnt_d = arm_val;
        rel_d = arm_val;
      end
    end else if (run_q && tick_en) begin
      if (expire_o) begin
        if (per_q) begin
          cnt_d = rel_q;
        end else begin
          cnt_d = '0;
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
      run_q <= 1'b0;
      per_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
      run_q <= run_d;
      per_q <= per_d;
    end
  end

  assign run_o    = run_q;
  assign per_o    = per_q;
  assign cnt_o    = cnt_q;
  assign reload_o = rel_q;
endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_set,
  input  logic mask_clr,
  input  logic pend_clr,
  input  logic expire,
  output logic mask_o,
  output logic pend_o,
  output logic irq_o
);
  logic mask_q, mask_d, pend_q, pend_d;

  always_comb begin
    mask_d = mask_q;
    if (mask_set)      mask_d = 1'b1;
    else if (mask_clr) mask_d = 1'b0;
    pend_d = pend_q;
    if (expire)        pend_d = 1'b1;
    else if (pend_clr) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign irq_o  = pend_q & mask_q;
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              run,
  input  logic              per,
  input  logic              mask,
  input  logic              pend,
  output logic [DATA_W-1:0] rdata,
  output logic              ctl_we,
  output logic              ctl_arm,
  output logic              ctl_run,
  output logic              ctl_per,
  output logic [CNT_W-1:0]  arm_val,
  output logic              mask_set,
  output logic              mask_clr,
  output logic              pend_clr
);
  logic [LOW_W-1:0] low_q, low_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic             low_we;

  always_comb begin
    low_we   = wr_en && (addr == OFS_LOW);
    ctl_we   = wr_en && (addr == OFS_CTL);
    ctl_arm  = wdata[BIT_ARM];
    ctl_run  = wdata[BIT_RUN];
    ctl_per  = wdata[BIT_PER];
    arm_val  = {wdata[HI_W-1:0], low_q};
    mask_set = wr_en && (addr == OFS_MSET) && wdata[0];
    mask_clr = wr_en && (addr == OFS_MCLR) && wdata[0];
    pend_clr = wr_en && (addr == OFS_PCLR) && wdata[0];
    low_d    = low_we ? wdata : low_q;
    hi_d     = ctl_we ? wdata[HI_W-1:0] : hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
      hi_q  <= '0;
    end else begin
      low_q <= low_d;
      hi_q  <= hi_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_LOW:  rdata = low_q;
      OFS_CTL: begin
        rdata[HI_W-1:0] = hi_q;
        rdata[BIT_RUN]  = run;
        rdata[BIT_PER]  = per;
      end
      OFS_MSET: rdata[0] = mask;
      OFS_PCLR: rdata[0] = pend;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);
  logic             ctl_we, ctl_arm, ctl_run, ctl_per;
  logic [CNT_W-1:0] arm_val, cnt_q, rel_q;
  logic             run_q, per_q, mask_q, pend_q, expire;
  logic             mask_set, mask_clr, pend_clr;

  evt_timer_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .run(run_q), .per(per_q), .mask(mask_q), .pend(pend_q), .rdata(rdata),
    .ctl_we(ctl_we), .ctl_arm(ctl_arm), .ctl_run(ctl_run), .ctl_per(ctl_per),
    .arm_val(arm_val), .mask_set(mask_set), .mask_clr(mask_clr),
    .pend_clr(pend_clr)
  );

  evt_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctl_we(ctl_we),
    .ctl_arm(ctl_arm), .ctl_run(ctl_run), .ctl_per(ctl_per),
    .arm_val(arm_val), .run_o(run_q), .per_o(per_q), .cnt_o(cnt_q),
    .reload_o(rel_q), .expire_o(expire)
  );

  evt_timer_irq u_irq (
    .clk(clk), .rst_n(rst_n), .mask_set(mask_set), .mask_clr(mask_clr),
    .pend_clr(pend_clr), .expire(expire), .mask_o(mask_q), .pend_o(pend_q),
    .irq_o(irq_o)
  );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CNT_W = 56
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             ctl_we,
  input logic             expire,
  input logic             run_q,
  input logic             per_q,
  input logic             pend_q,
  input logic             mask_q,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] rel_q
);
  // R8
  pend_on_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend_q);
  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !per_q) |=> !run_q);
  // R6
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && per_q) |=> (run_q && cnt_q == $past(rel_q)));
  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_en && !ctl_we && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R4
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ctl_we) |=> $stable(cnt_q));
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_q && pend_q));
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(evt_timer_pkg::CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctl_we(ctl_we),
  .expire(expire), .run_q(run_q), .per_q(per_q), .pend_q(pend_q),
  .mask_q(mask_q), .irq_o(irq_o), .cnt_q(cnt_q), .rel_q(rel_q)
);

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
  logic        clk, rst_n, tick_en, wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq_o;
  int          n_chk, n_bad;

  localparam logic [31:0] RUN = 32'h0100_0000;
  localparam logic [31:0] PER = 32'h1000_0000;
  localparam logic [31:0] ARM = 32'h4000_0000;

  evt_timer u_evt_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk = 1'b0);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; tick_en = tk;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(req, rdata, exp);
  endtask

  task automatic ticks(input int n, input int gap = 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  task automatic pend_is(input string req, input logic v);
    rd_chk(req, 8'h34, {31'b0, v});
  endtask

  task automatic clr_pend();
    wr(8'h34, 32'h1);
  endtask

  task automatic t_reset();
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    rd_chk("R1 low", 8'h00, 0);
    rd_chk("R1 ctl", 8'h04, 0);
    rd_chk("R1 mask", 8'h2c, 0);
    rd_chk("R1 pend", 8'h34, 0);
  endtask

  task automatic t_regs();
    wr(8'h00, 32'hA5A5_1234);
    rd_chk("R2 low rw", 8'h00, 32'hA5A5_1234);
    wr(8'h04, 32'hFFFF_FFFF & ~RUN);
    rd_chk("R2 ctl readback", 8'h04, 32'h1000_0000 | 32'h00FF_FFFF);
    wr(8'h04, 0);
    rd_chk("R7 ctl zero", 8'h04, 0);
  endtask

  task automatic t_oneshot(input logic [31:0] n);
    wr(8'h00, n);
    wr(8'h04, ARM | RUN);
    ticks(n - 1, 2);
    pend_is("R3 no early expiry", 1'b0);
    ticks(1);
    pend_is("R3 expiry on Nth tick", 1'b1);
    rd_chk("R5 run cleared", 8'h04, 0);
    clr_pend();
    ticks(4);
    pend_is("R5 no second expiry", 1'b0);
  endtask

  task automatic t_high_bits();
    wr(8'h00, 0);
    wr(8'h04, ARM | RUN | 32'h1);
    ticks(12);
    pend_is("R3 upper bits counted", 1'b0);
    rd_chk("R3 still running", 8'h04, RUN | 32'h1);
    wr(8'h04, 0);
    ticks(3);
    pend_is("R7 stopped", 1'b0);
  endtask

  task automatic t_periodic();
    wr(8'h00, 3);
    wr(8'h04, ARM | RUN | PER);
    wr(8'h00, 7);
    for (int p = 0; p < 3; p++) begin
      ticks(2);
      pend_is("R6 no early expiry", 1'b0);
      ticks(1);
      pend_is("R6 period expiry", 1'b1);
      clr_pend();
    end
    rd_chk("R6 still running", 8'h04, RUN | PER);
    wr(8'h04, 0);
    ticks(5);
    pend_is("R7 periodic stopped", 1'b0);
  endtask

  task automatic t_mask();
    wr(8'h2c, 32'hFFFF_FFFE);
    rd_chk("R9 set bit0=0 ignored", 8'h2c, 0);
    wr(8'h00, 1);
    wr(8'h04, ARM | RUN);
    ticks(1);
    pend_is("R8 pending while masked", 1'b1);
    chk("R10 irq low when masked", {31'b0, irq_o}, 0);
    wr(8'h2c, 32'h1);
    rd_chk("R9 mask set", 8'h2c, 1);
    chk("R10 irq high", {31'b0, irq_o}, 1);
    wr(8'h30, 32'h0);
    rd_chk("R9 clr bit0=0 ignored", 8'h2c, 1);
    wr(8'h30, 32'h1);
    rd_chk("R9 mask cleared", 8'h2c, 0);
    chk("R10 irq low after clear mask", {31'b0, irq_o}, 0);
    wr(8'h2c, 32'h1);
    wr(8'h34, 32'h0);
    pend_is("R11 clr bit0=0 ignored", 1'b1);
    clr_pend();
    pend_is("R11 cleared", 1'b0);
    chk("R10 irq low no pending", {31'b0, irq_o}, 0);
  endtask

  task automatic t_collide();
    // R11: clear and expiry in same cycle, expiry wins
    wr(8'h00, 1);
    wr(8'h04, ARM | RUN);
    ticks(0);
    @(negedge clk);
    addr = 8'h34; wdata = 1; wr_en = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    pend_is("R11 expiry beats clear", 1'b1);
    clr_pend();
    // R12: strobe with control write ignored
    wr(8'h00, 3);
    wr(8'h04, ARM | RUN, 1'b1);
    ticks(2);
    pend_is("R12 strobe ignored", 1'b0);
    ticks(1);
    pend_is("R12 expiry on third", 1'b1);
    clr_pend();
    wr(8'h2c, 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_oneshot(1);
    t_oneshot(3);
    t_oneshot(5);
    t_high_bits();
    t_periodic();
    t_mask();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule